// File: doc/BRIEF.md
# USB Device Bus Suspend and Resume Controller

This block watches the decoded line state of a USB device port and raises the power-management events that firmware reacts to. When the bus has stayed idle for a set number of milliseconds, it flags a suspend. Any later departure from idle flags a wake-up. Firmware can ask for a remote wake-up while the bus is suspended. The block holds that request until the bus has been quiet long enough, then drives a resume K state on the bus for a fixed time and clears the request itself. It also recognises the host's end-of-resume sequence and keeps the pull-up disconnect bit that firmware uses to force a re-enumeration.

Every time base comes from one parameter, the count of clock cycles per millisecond. The suspend threshold, the quiet time before remote wake-up and the resume drive length are each a parameter given in milliseconds. Each line state is accepted only after it has been sampled unchanged for a parameterized number of cycles. All event flags are sticky. Each has its own one-cycle clear strobe.

Top module: `usbpm_ctrl`

## Requirements
- R1: After reset, the flags `susp`, `wakeup`, `uprsm` and `eorsm` read 0, `rmwkup` reads 0, `resume_drive` reads 0 and `detach` reads 1.
- R2: `line_state` is coded as 2'b00 SE0, 2'b01 J (idle), 2'b10 K and 2'b11 SE1. A new state takes effect only after it has been sampled for QUAL_CYC consecutive cycles (default 2). A shorter pulse has no effect on any flag.
- R3: `susp` is set once the qualified line has been J continuously for SUSP_MS milliseconds (3 by default). This happens once per idle period.
- R4: `wakeup` is set on every qualified change of the line from J to any other state, whether the bus was suspended or not.
- R5: Setting `susp` clears `wakeup` in the same cycle, and setting `wakeup` clears `susp` in the same cycle. The two flags never read 1 together.
- R6: A pulse on `wr_rmwkup` sets `rmwkup` only while the bus is suspended, meaning the SUSP threshold has been reached with no activity since. At any other time the pulse is ignored and `rmwkup` stays 0.
- R7: While `rmwkup` is 1, `resume_drive` rises once the line has been J continuously for RWK_MS milliseconds (5 by default). This takes effect on the cycle after the write if that much idle time has already passed. In the cycle `resume_drive` rises, `uprsm` is set and `susp` is cleared.
- R8: `resume_drive` stays 1 for exactly RESUME_MS × CYC_PER_MS cycles (2 ms by default). `rmwkup` returns to 0 in the cycle it falls.
- R9: Qualified activity (a line state other than J) while `rmwkup` is 1 but before the drive has begun cancels the request. `rmwkup` returns to 0 and no resume is driven.
- R10: `eorsm` is set when the qualified line goes K, then SE0, then J, in that order. Any other order leaves it clear.
- R11: Each flag stays 1 until a pulse on its own clear strobe (`clr_susp`, `clr_wakeup`, `clr_uprsm`, `clr_eorsm`). If a set event and a clear strobe arrive in the same cycle, the set wins.
- R12: A pulse on `detach_we` loads `detach_wdata` into `detach` on the next edge, so writing 1 and then 0 disconnects and then reconnects the pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_state | input | 2 | Decoded bus state from the transceiver |
| wr_rmwkup | input | 1 | Firmware request for remote wake-up |
| clr_susp | input | 1 | Clears the suspend flag |
| clr_wakeup | input | 1 | Clears the wake-up flag |
| clr_uprsm | input | 1 | Clears the upstream-resume flag |
| clr_eorsm | input | 1 | Clears the end-of-resume flag |
| detach_we | input | 1 | Write strobe for the pull-up disconnect bit |
| detach_wdata | input | 1 | Value written to the disconnect bit |
| susp | output | 1 | Suspend detected flag |
| wakeup | output | 1 | Bus activity detected flag |
| uprsm | output | 1 | Upstream resume started flag |
| eorsm | output | 1 | Host end of resume detected flag |
| rmwkup | output | 1 | Remote wake-up request pending |
| resume_drive | output | 1 | Asks the transceiver to drive K |
| detach | output | 1 | Pull-up disconnect control |

## Verification
A fault in the idle millisecond count shows up as `susp` or `resume_drive` rising tens of cycles early or late. The bench measures this against windows in the small configuration. If the drive counter ends at the wrong value, the count of `resume_drive` high cycles is wrong at the moment it falls. A stuck suspended-state bit shows up on the next `wr_rmwkup` as a request accepted or lost. A wrong step in the end-of-resume tracker shows up within a few cycles of the final J, as `eorsm` raised for a glitched or missing SE0 or left clear for a proper sequence.

// File: rtl/usbpm_pkg.sv
package usbpm_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    RW_OFF,
    RW_WAIT,
    RW_DRIVE
  } rw_state_t;

  typedef enum logic [1:0] {
    EO_NONE,
    EO_K,
    EO_SE0
  } eor_state_t;
endpackage

// File: rtl/usbpm_line_qual.sv
module usbpm_line_qual
  import usbpm_pkg::*;
#(
  parameter int QUAL_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] line_i,
  output line_t      line_q_o,
  output logic       chg_o,
  output logic       act_o
);
  localparam int QW = $clog2(QUAL_CYC + 1);

  logic [1:0]    samp;
  logic [QW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp     <= LS_J;
      run      <= '0;
      line_q_o <= LS_J;
      chg_o    <= 1'b0;
      act_o    <= 1'b0;
    end else begin
      samp  <= line_i;
      chg_o <= 1'b0;
      act_o <= 1'b0;
      if (line_i != samp) run <= QW'(1);
      else if (run != QW'(QUAL_CYC)) run <= run + 1'b1;
      if (run == QW'(QUAL_CYC) && line_t'(samp) != line_q_o) begin
        line_q_o <= line_t'(samp);
        chg_o    <= 1'b1;
        act_o    <= (line_q_o == LS_J);
      end
    end
  end
endmodule

// File: rtl/usbpm_idle_timer.sv
module usbpm_idle_timer #(
  parameter int CYC_PER_MS = 60000,
  parameter int MS_MAX     = 5,
  localparam int MSW       = $clog2(MS_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           restart_i,
  output logic [MSW-1:0] ms_o
);
  localparam int CW = $clog2(CYC_PER_MS);

  logic [CW-1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cyc  <= '0;
      ms_o <= '0;
    end else if (ms_o != MSW'(MS_MAX)) begin
      if (cyc == CW'(CYC_PER_MS - 1)) begin
        cyc  <= '0;
        ms_o <= ms_o + 1'b1;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/usbpm_remote_wake.sv
module usbpm_remote_wake
  import usbpm_pkg::*;
#(
  parameter int CYC_PER_MS = 60000,
  parameter int RESUME_MS  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic cancel_i,
  input  logic idle_ok_i,
  output logic pending_o,
  output logic drive_o,
  output logic start_o
);
  localparam int DRV_CYC = RESUME_MS * CYC_PER_MS;
  localparam int DW      = $clog2(DRV_CYC);

  rw_state_t     st;
  logic [DW-1:0] cnt;

  assign start_o   = (st == RW_WAIT) && !cancel_i && idle_ok_i;
  assign pending_o = (st != RW_OFF);
  assign drive_o   = (st == RW_DRIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= RW_OFF;
      cnt <= '0;
    end else begin
      case (st)
        RW_OFF: if (req_i) st <= RW_WAIT;
        RW_WAIT: begin
          if (cancel_i) st <= RW_OFF;
          else if (idle_ok_i) begin
            st  <= RW_DRIVE;
            cnt <= '0;
          end
        end
        RW_DRIVE: begin
          if (cnt == DW'(DRV_CYC - 1)) st <= RW_OFF;
          else cnt <= cnt + 1'b1;
        end
        default: st <= RW_OFF;
      endcase
    end
  end
endmodule

// File: rtl/usbpm_eor_detect.sv
module usbpm_eor_detect
  import usbpm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  line_t line_q_i,
  input  logic  chg_i,
  output logic  eor_o
);
  eor_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= EO_NONE;
      eor_o <= 1'b0;
    end else begin
      eor_o <= 1'b0;
      if (chg_i) begin
        case (line_q_i)
          LS_K:    st <= EO_K;
          LS_SE0:  st <= (st == EO_K) ? EO_SE0 : EO_NONE;
          LS_J: begin
            eor_o <= (st == EO_SE0);
            st    <= EO_NONE;
          end
          default: st <= EO_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/usbpm_ctrl.sv
module usbpm_ctrl
  import usbpm_pkg::*;
#(
  parameter int CYC_PER_MS = 60000,
  parameter int SUSP_MS    = 3,
  parameter int RWK_MS     = 5,
  parameter int RESUME_MS  = 2,
  parameter int QUAL_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] line_state,
  input  logic       wr_rmwkup,
  input  logic       clr_susp,
  input  logic       clr_wakeup,
  input  logic       clr_uprsm,
  input  logic       clr_eorsm,
  input  logic       detach_we,
  input  logic       detach_wdata,
  output logic       susp,
  output logic       wakeup,
  output logic       uprsm,
  output logic       eorsm,
  output logic       rmwkup,
  output logic       resume_drive,
  output logic       detach
);
  localparam int MS_MAX = (SUSP_MS > RWK_MS) ? SUSP_MS : RWK_MS;
  localparam int MSW    = $clog2(MS_MAX + 1);

  line_t          line_q;
  logic           chg, act, eor, start, restart, susp_done;
  logic           susp_evt, idle_ok, req_ok;
  logic [MSW-1:0] idle_ms;

  usbpm_line_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk(clk), .rst(rst), .line_i(line_state),
    .line_q_o(line_q), .chg_o(chg), .act_o(act)
  );

  assign restart = (line_q != LS_J) || resume_drive;

  usbpm_idle_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_MAX(MS_MAX)) u_idle (
    .clk(clk), .rst(rst), .restart_i(restart), .ms_o(idle_ms)
  );

  assign susp_evt = (idle_ms >= MSW'(SUSP_MS)) && !susp_done && !restart;
  assign idle_ok  = (idle_ms >= MSW'(RWK_MS)) && !restart;
  assign req_ok   = wr_rmwkup && susp_done;

  usbpm_remote_wake #(.CYC_PER_MS(CYC_PER_MS), .RESUME_MS(RESUME_MS)) u_rwk (
    .clk(clk), .rst(rst), .req_i(req_ok), .cancel_i(line_q != LS_J),
    .idle_ok_i(idle_ok), .pending_o(rmwkup), .drive_o(resume_drive),
    .start_o(start)
  );

  usbpm_eor_detect u_eor (
    .clk(clk), .rst(rst), .line_q_i(line_q), .chg_i(chg), .eor_o(eor)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      susp_done <= 1'b0;
      susp      <= 1'b0;
      wakeup    <= 1'b0;
      uprsm     <= 1'b0;
      eorsm     <= 1'b0;
      detach    <= 1'b1;
    end else begin
      if (restart) susp_done <= 1'b0;
      else if (susp_evt) susp_done <= 1'b1;

      if (susp_evt) susp <= 1'b1;
      else if (act || start || clr_susp) susp <= 1'b0;

      if (act) wakeup <= 1'b1;
      else if (susp_evt || clr_wakeup) wakeup <= 1'b0;

      if (start) uprsm <= 1'b1;
      else if (clr_uprsm) uprsm <= 1'b0;

      if (eor) eorsm <= 1'b1;
      else if (clr_eorsm) eorsm <= 1'b0;

      if (detach_we) detach <= detach_wdata;
    end
  end
endmodule

// File: rtl/usbpm_ctrl_chk.sv
module usbpm_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] line_state,
  input logic       wr_rmwkup,
  input logic       clr_susp,
  input logic       clr_wakeup,
  input logic       clr_uprsm,
  input logic       clr_eorsm,
  input logic       detach_we,
  input logic       detach_wdata,
  input logic       susp,
  input logic       wakeup,
  input logic       uprsm,
  input logic       eorsm,
  input logic       rmwkup,
  input logic       resume_drive,
  input logic       detach
);
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(susp && wakeup));

  a_r6_pending_needs_write: assert property (@(posedge clk) disable iff (rst)
    $rose(rmwkup) |-> $past(wr_rmwkup));

  a_r7_drive_sets_uprsm: assert property (@(posedge clk) disable iff (rst)
    $rose(resume_drive) |-> (uprsm && !susp));

  a_r8_drive_implies_pending: assert property (@(posedge clk) disable iff (rst)
    resume_drive |-> rmwkup);

  a_r8_pending_ends_with_drive: assert property (@(posedge clk) disable iff (rst)
    $fell(resume_drive) |-> !rmwkup);

  a_r11_uprsm_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(uprsm) |-> $past(clr_uprsm));

  a_r11_eorsm_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(eorsm) |-> $past(clr_eorsm));

  a_r12_detach_write: assert property (@(posedge clk) disable iff (rst)
    detach_we |=> (detach == $past(detach_wdata)));
endmodule

bind usbpm_ctrl usbpm_ctrl_chk u_chk (.*);

// File: tb/usbpm_ctrl_bench.sv
module usbpm_ctrl_bench;
  localparam int CPM = 20;
  localparam int DRV = 2 * CPM;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] line_state = 2'b01;
  logic       wr_rmwkup = 1'b0, clr_susp = 1'b0, clr_wakeup = 1'b0;
  logic       clr_uprsm = 1'b0, clr_eorsm = 1'b0;
  logic       detach_we = 1'b0, detach_wdata = 1'b0;
  logic       susp, wakeup, uprsm, eorsm, rmwkup, resume_drive, detach;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  usbpm_ctrl #(.CYC_PER_MS(CPM), .SUSP_MS(3), .RWK_MS(5), .RESUME_MS(2),
               .QUAL_CYC(2)) u_usbpm_ctrl (
    .clk(clk), .rst(rst), .line_state(line_state), .wr_rmwkup(wr_rmwkup),
    .clr_susp(clr_susp), .clr_wakeup(clr_wakeup), .clr_uprsm(clr_uprsm),
    .clr_eorsm(clr_eorsm), .detach_we(detach_we), .detach_wdata(detach_wdata),
    .susp(susp), .wakeup(wakeup), .uprsm(uprsm), .eorsm(eorsm),
    .rmwkup(rmwkup), .resume_drive(resume_drive), .detach(detach)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    // R1 reset state
    chk_eq("R1 susp", susp, 0);
    chk_eq("R1 wakeup", wakeup, 0);
    chk_eq("R1 uprsm", uprsm, 0);
    chk_eq("R1 eorsm", eorsm, 0);
    chk_eq("R1 rmwkup", rmwkup, 0);
    chk_eq("R1 drive", resume_drive, 0);
    chk_eq("R1 detach", detach, 1);

    // R12 detach writes
    detach_we = 1'b1; detach_wdata = 1'b0; tick(1);
    chk_eq("R12 detach0", detach, 0);
    detach_wdata = 1'b1; tick(1);
    detach_we = 1'b0;
    chk_eq("R12 detach1", detach, 1);

    // R3 suspend after 3 ms idle (60 cycles)
    tick(46);
    chk_eq("R3 early", susp, 0);
    tick(20);
    chk_eq("R3 set", susp, 1);

    // R4 and R5: activity sets wakeup, clears susp
    line_state = 2'b10; tick(6);
    chk_eq("R4 wakeup", wakeup, 1);
    chk_eq("R5 susp cleared", susp, 0);
    line_state = 2'b01; tick(4);

    // R6 request ignored when not suspended
    wr_rmwkup = 1'b1; tick(1); wr_rmwkup = 1'b0; tick(2);
    chk_eq("R6 ignored", rmwkup, 0);
    tick(110);
    chk_eq("R6 no drive", resume_drive, 0);
    chk_eq("R5 susp set", susp, 1);
    chk_eq("R5 wakeup cleared", wakeup, 0);

    // R7 / R8 sweep over write times
    for (int i = 0; i < 4; i++) begin
      int wd, c, start, len, expst;
      bit done;
      case (i)
        0: wd = 70;
        1: wd = 85;
        2: wd = 100;
        default: wd = 130;
      endcase
      expst = (wd + 1 > 102) ? wd + 1 : 102;
      line_state = 2'b10; tick(6); line_state = 2'b01;
      c = 0; start = -1; len = 0; done = 1'b0;
      while (!done && c < 400) begin
        @(negedge clk);
        c++;
        wr_rmwkup = (c == wd);
        if (c == wd + 2) chk_eq("R7 pending", rmwkup, 1);
        if (resume_drive) begin
          if (start < 0) begin
            start = c;
            check((start >= expst - 5) && (start <= expst + 5), "R7 start", start, expst);
            chk_eq("R7 uprsm", uprsm, 1);
            chk_eq("R7 susp clr", susp, 0);
          end
          len++;
        end else if (start >= 0) begin
          done = 1'b1;
          chk_eq("R8 length", len, DRV);
          chk_eq("R8 rmwkup clr", rmwkup, 0);
        end
      end
      check(done, "R7 drive seen", done, 1);
      clr_uprsm = 1'b1; tick(1); clr_uprsm = 1'b0;
      chk_eq("R11 uprsm clr", uprsm, 0);
    end

    // R10 end of resume
    chk_eq("R10 none yet", eorsm, 0);
    line_state = 2'b10; tick(5);
    line_state = 2'b00; tick(1);
    line_state = 2'b01; tick(5);
    chk_eq("R10 short se0", eorsm, 0);
    line_state = 2'b10; tick(5);
    line_state = 2'b00; tick(3);
    line_state = 2'b01; tick(5);
    chk_eq("R10 eor", eorsm, 1);
    tick(20);
    chk_eq("R11 eorsm sticky", eorsm, 1);
    clr_eorsm = 1'b1; tick(1); clr_eorsm = 1'b0;
    chk_eq("R11 eorsm clr", eorsm, 0);

    // R2 qualification
    clr_wakeup = 1'b1; tick(1); clr_wakeup = 1'b0;
    chk_eq("R11 wakeup clr", wakeup, 0);
    line_state = 2'b10; tick(1); line_state = 2'b01; tick(6);
    chk_eq("R2 glitch", wakeup, 0);
    line_state = 2'b10; tick(2); line_state = 2'b01; tick(6);
    chk_eq("R2 two cycles", wakeup, 1);

    // R9 cancel while waiting
    tick(70);
    chk_eq("R9 susp", susp, 1);
    wr_rmwkup = 1'b1; tick(1); wr_rmwkup = 1'b0; tick(2);
    chk_eq("R9 pending", rmwkup, 1);
    clr_susp = 1'b1; tick(1); clr_susp = 1'b0;
    chk_eq("R11 susp clr", susp, 0);
    tick(8);
    line_state = 2'b10; tick(4); line_state = 2'b01; tick(2);
    chk_eq("R9 cancelled", rmwkup, 0);
    begin
      int hi;
      hi = 0;
      for (int k = 0; k < 150; k++) begin
        @(negedge clk);
        if (resume_drive) hi++;
      end
      chk_eq("R9 no drive", hi, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule